// File: doc/BRIEF.md
# Mismatch-Indexed Route Selector

This block makes the routing decision for a packet switch. A header arrives with a destination node identifier, the network it travels on and the link it came in on. The block compares the destination with the local node identifier and finds the most significant bit where they differ. That bit position selects one of sixteen programmable 4-bit direction entries. The block then picks an outgoing link that belongs to that direction and that network.

Each link has its own configuration word. The word holds the link's direction, a 2-bit network number, a static flag and a channel-end number. When a header arrives on a static link, routing is skipped and the packet goes to that link's channel end. A destination equal to the local identifier is delivered to the local processor. When no link is configured for the chosen direction and network, the packet is flagged as junk. When such links exist but none of them is idle, the result reports busy.

The decision is registered, so it appears one cycle after the header is presented. Configuration is written through a simple word-wide register port and can be read back combinationally.

Top module: `mism_router`

## Requirements
- R1: After reset, `resValid` is low and every configuration register reads back as zero.
- R2: Configuration writes and reads use these word addresses. Address 1 holds the local identifier in bits [15:0]. Address 2 holds direction entries for positions 0..7. Address 3 holds entries for positions 8..15. Addresses 8..15 each hold one link's word: bit 31 static, bits [25:24] network, bits [19:16] direction, bits [7:0] channel end. Unlisted bits read as zero. A write to any other address changes nothing and reads back zero.
- R3: A header accepted with `hdrValid` produces `resValid` high for exactly the next cycle. The result fields hold their values until the next header.
- R4: If the destination equals the local identifier and the incoming link is not static, `resLocal` is 1 and the other flags, `resDir`, `resLink` and `resChanEnd` are 0.
- R5: `resDir` is the entry at the most significant differing bit position p. Position p occupies bits [4*(p mod 8)+3 : 4*(p mod 8)] of register 2 (p<8) or register 3 (p>=8).
- R6: A routed packet takes the lowest-indexed link that is idle, not static, and whose direction and network both match. `resLink` gives the index of that link.
- R7: If no non-static link has a matching direction and network, `resErr` (junk) is 1, `resDir` shows the chosen direction and `resLink` is 0.
- R8: If matching links exist but none is idle, `resBusy` is 1, `resErr` is 0 and `resLink` is 0.
- R9: A header arriving on a static link gives `resStatic`=1 and `resChanEnd` equal to that link's channel end. All other flags, `resDir` and `resLink` are 0, even when the destination matches the local identifier.
- R10: Static links are never chosen as routed outputs, whatever their direction and network fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 6 | Configuration word address |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Combinational read data at `cfgAddr` |
| hdrValid | input | 1 | Header present this cycle |
| hdrDest | input | 16 | Destination node identifier |
| hdrNet | input | 2 | Network the packet travels on |
| hdrLink | input | 3 | Link the header arrived on |
| linkIdle | input | 8 | One bit per link, high when the link can accept a packet |
| resValid | output | 1 | Result valid, one cycle after the header |
| resLocal | output | 1 | Deliver to the local processor |
| resStatic | output | 1 | Forwarded to a static channel end |
| resErr | output | 1 | No link configured; packet is junk |
| resBusy | output | 1 | Matching links exist but all are busy |
| resDir | output | 4 | Chosen direction |
| resLink | output | 3 | Selected output link |
| resChanEnd | output | 8 | Channel end for static forwarding |

## Verification
The hardest situation to reach is one where direction, network, idle state and the static flag compete at once. An example is a static link whose direction and network fields would otherwise win priority, together with a lower-indexed candidate that is busy. The stimulus first programs a link map in which every direction entry equals its own bit position. It gives two links the same direction and network and places a static link between them. A vector table then varies the destination's differing bit, the network and the idle mask, so that each case lands on exactly one of the outcomes: winner, junk, busy, local or static. Finally a direction entry is reprogrammed and the same header is sent again, to show that the lookup tracks the register contents.

// File: rtl/mism_router_pkg.sv
package mism_router_pkg;
  localparam int LINK_IDX_W = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LOCAL,
    SEL_DIR_LO,
    SEL_DIR_HI,
    SEL_LINK
  } reg_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    reg_sel_e              regSel;
    logic [LINK_IDX_W-1:0] linkIdx;
    logic                  wrStb;
    logic                  capture;
  } dp_ctrl_t;
endpackage

// File: rtl/mism_router_ctrl.sv
module mism_router_ctrl
  import mism_router_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_LINKS = 8,
  parameter int LINK_BASE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              hdrValid,
  output dp_ctrl_t          ctl,
  output logic              resValid
);
  localparam logic [ADDR_W-1:0] ADDR_LOCAL  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_DIR_LO = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_DIR_HI = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] LINK_LO     = ADDR_W'(LINK_BASE);
  localparam logic [ADDR_W-1:0] LINK_HI     = ADDR_W'(LINK_BASE + NUM_LINKS);

  logic [ADDR_W-1:0] linkOfs;
  assign linkOfs = cfgAddr - LINK_LO;

  always_comb begin
    ctl         = '0;
    ctl.regSel  = SEL_NONE;
    if (cfgAddr == ADDR_LOCAL)       ctl.regSel = SEL_LOCAL;
    else if (cfgAddr == ADDR_DIR_LO) ctl.regSel = SEL_DIR_LO;
    else if (cfgAddr == ADDR_DIR_HI) ctl.regSel = SEL_DIR_HI;
    else if (cfgAddr >= LINK_LO && cfgAddr < LINK_HI) begin
      ctl.regSel  = SEL_LINK;
      ctl.linkIdx = LINK_IDX_W'(linkOfs);
    end
    ctl.wrStb   = cfgWrEn;
    ctl.capture = hdrValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= hdrValid;
  end
endmodule

// File: rtl/mism_router_dp.sv
module mism_router_dp
  import mism_router_pkg::*;
#(
  parameter int NODE_W    = 16,
  parameter int DIR_W     = 4,
  parameter int NET_W     = 2,
  parameter int CHAN_W    = 8,
  parameter int NUM_LINKS = 8,
  parameter int DATA_W    = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dp_ctrl_t                     ctl,
  input  logic [DATA_W-1:0]            cfgWrData,
  output logic [DATA_W-1:0]            cfgRdData,
  input  logic [NODE_W-1:0]            hdrDest,
  input  logic [NET_W-1:0]             hdrNet,
  input  logic [$clog2(NUM_LINKS)-1:0] hdrLink,
  input  logic [NUM_LINKS-1:0]         linkIdle,
  output logic                         resLocal,
  output logic                         resStatic,
  output logic                         resErr,
  output logic                         resBusy,
  output logic [DIR_W-1:0]             resDir,
  output logic [$clog2(NUM_LINKS)-1:0] resLink,
  output logic [CHAN_W-1:0]            resChanEnd
);
  localparam int LINK_W     = $clog2(NUM_LINKS);
  localparam int POS_W      = $clog2(NODE_W);
  localparam int TBL_W      = NODE_W * DIR_W;
  localparam int STATIC_BIT = DATA_W - 1;
  localparam int NET_LSB    = 24;
  localparam int DIR_LSB    = 16;
  localparam int CHAN_LSB   = 0;

  logic [NODE_W-1:0] localId;
  logic [TBL_W-1:0]  dirTbl;
  logic              lnkStatic [NUM_LINKS];
  logic [NET_W-1:0]  lnkNet    [NUM_LINKS];
  logic [DIR_W-1:0]  lnkDir    [NUM_LINKS];
  logic [CHAN_W-1:0] lnkChan   [NUM_LINKS];

  // global configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      localId <= '0;
      dirTbl  <= '0;
    end else if (ctl.wrStb) begin
      case (ctl.regSel)
        SEL_LOCAL:  localId                <= cfgWrData[NODE_W-1:0];
        SEL_DIR_LO: dirTbl[DATA_W-1:0]     <= cfgWrData;
        SEL_DIR_HI: dirTbl[TBL_W-1:DATA_W] <= cfgWrData;
        default: ;
      endcase
    end
  end

  // per-link configuration words
  logic [NUM_LINKS-1:0] cfgMatch;
  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
    logic hit;
    assign hit = ctl.wrStb && (ctl.regSel == SEL_LINK) &&
                 (ctl.linkIdx == LINK_IDX_W'(i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lnkStatic[i] <= 1'b0;
        lnkNet[i]    <= '0;
        lnkDir[i]    <= '0;
        lnkChan[i]   <= '0;
      end else if (hit) begin
        lnkStatic[i] <= cfgWrData[STATIC_BIT];
        lnkNet[i]    <= cfgWrData[NET_LSB +: NET_W];
        lnkDir[i]    <= cfgWrData[DIR_LSB +: DIR_W];
        lnkChan[i]   <= cfgWrData[CHAN_LSB +: CHAN_W];
      end
    end
  end

  // read-back mux
  always_comb begin
    cfgRdData = '0;
    case (ctl.regSel)
      SEL_LOCAL:  cfgRdData[NODE_W-1:0] = localId;
      SEL_DIR_LO: cfgRdData = dirTbl[DATA_W-1:0];
      SEL_DIR_HI: cfgRdData = dirTbl[TBL_W-1:DATA_W];
      SEL_LINK: begin
        for (int i = 0; i < NUM_LINKS; i++) begin
          if (ctl.linkIdx == LINK_IDX_W'(i)) begin
            cfgRdData[STATIC_BIT]         = lnkStatic[i];
            cfgRdData[NET_LSB +: NET_W]   = lnkNet[i];
            cfgRdData[DIR_LSB +: DIR_W]   = lnkDir[i];
            cfgRdData[CHAN_LSB +: CHAN_W] = lnkChan[i];
          end
        end
      end
      default: ;
    endcase
  end

  // leading-one of the identifier difference
  logic [NODE_W-1:0] diffBits;
  logic [POS_W-1:0]  mismPos;
  logic [DIR_W-1:0]  chosenDir;
  assign diffBits = hdrDest ^ localId;

  always_comb begin
    mismPos = '0;
    for (int p = 0; p < NODE_W; p++)
      if (diffBits[p]) mismPos = POS_W'(p);
  end

  always_comb begin
    chosenDir = '0;
    for (int p = 0; p < NODE_W; p++)
      if (mismPos == POS_W'(p)) chosenDir = dirTbl[p*DIR_W +: DIR_W];
  end

  // candidate links and lowest-index winner
  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_cand
    assign cfgMatch[i] = !lnkStatic[i] && (lnkDir[i] == chosenDir) &&
                         (lnkNet[i] == hdrNet);
  end

  logic [NUM_LINKS-1:0] readyMatch;
  logic [LINK_W-1:0]    winner;
  assign readyMatch = cfgMatch & linkIdle;

  always_comb begin
    winner = '0;
    for (int i = NUM_LINKS - 1; i >= 0; i--)
      if (readyMatch[i]) winner = LINK_W'(i);
  end

  // next result
  logic              inStatic, isLocal;
  logic              nLocal, nStatic, nErr, nBusy;
  logic [DIR_W-1:0]  nDir;
  logic [LINK_W-1:0] nLink;
  logic [CHAN_W-1:0] nChan;
  assign inStatic = lnkStatic[hdrLink];
  assign isLocal  = (diffBits == '0);

  always_comb begin
    nLocal = 1'b0; nStatic = 1'b0; nErr = 1'b0; nBusy = 1'b0;
    nDir = '0; nLink = '0; nChan = '0;
    if (inStatic) begin
      nStatic = 1'b1;
      nChan   = lnkChan[hdrLink];
    end else if (isLocal) begin
      nLocal = 1'b1;
    end else begin
      nDir = chosenDir;
      if (cfgMatch == '0)        nErr  = 1'b1;
      else if (readyMatch == '0) nBusy = 1'b1;
      else                       nLink = winner;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resLocal <= 1'b0; resStatic <= 1'b0; resErr <= 1'b0; resBusy <= 1'b0;
      resDir <= '0; resLink <= '0; resChanEnd <= '0;
    end else if (ctl.capture) begin
      resLocal <= nLocal; resStatic <= nStatic; resErr <= nErr; resBusy <= nBusy;
      resDir <= nDir; resLink <= nLink; resChanEnd <= nChan;
    end
  end

  // R3
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable({resLocal, resStatic, resErr, resBusy, resDir, resLink, resChanEnd}));

  // R7
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({resLocal, resStatic, resErr, resBusy}));

  // R6
  winner_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.capture) && !(resLocal || resStatic || resErr || resBusy)
      |-> ((($past(linkIdle) >> resLink) & NUM_LINKS'(1)) != '0));

  // R10
  winner_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.capture) && !$past(ctl.wrStb) && !(resLocal || resStatic || resErr || resBusy)
      |-> (!lnkStatic[resLink] && lnkDir[resLink] == resDir));
endmodule

// File: rtl/mism_router.sv
module mism_router
  import mism_router_pkg::*;
#(
  parameter int NODE_W    = 16,
  parameter int DIR_W     = 4,
  parameter int NET_W     = 2,
  parameter int CHAN_W    = 8,
  parameter int NUM_LINKS = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int LINK_BASE = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgWrEn,
  input  logic [ADDR_W-1:0]            cfgAddr,
  input  logic [DATA_W-1:0]            cfgWrData,
  output logic [DATA_W-1:0]            cfgRdData,
  input  logic                         hdrValid,
  input  logic [NODE_W-1:0]            hdrDest,
  input  logic [NET_W-1:0]             hdrNet,
  input  logic [$clog2(NUM_LINKS)-1:0] hdrLink,
  input  logic [NUM_LINKS-1:0]         linkIdle,
  output logic                         resValid,
  output logic                         resLocal,
  output logic                         resStatic,
  output logic                         resErr,
  output logic                         resBusy,
  output logic [DIR_W-1:0]             resDir,
  output logic [$clog2(NUM_LINKS)-1:0] resLink,
  output logic [CHAN_W-1:0]            resChanEnd
);
  dp_ctrl_t ctl;

  mism_router_ctrl #(
    .ADDR_W(ADDR_W), .NUM_LINKS(NUM_LINKS), .LINK_BASE(LINK_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .hdrValid(hdrValid), .ctl(ctl), .resValid(resValid)
  );

  mism_router_dp #(
    .NODE_W(NODE_W), .DIR_W(DIR_W), .NET_W(NET_W), .CHAN_W(CHAN_W),
    .NUM_LINKS(NUM_LINKS), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .hdrDest(hdrDest), .hdrNet(hdrNet),
    .hdrLink(hdrLink), .linkIdle(linkIdle), .resLocal(resLocal),
    .resStatic(resStatic), .resErr(resErr), .resBusy(resBusy),
    .resDir(resDir), .resLink(resLink), .resChanEnd(resChanEnd)
  );
endmodule

// File: tb/sim_mism_router.sv
module sim_mism_router;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        hdrValid = 1'b0;
  logic [15:0] hdrDest = '0;
  logic [1:0]  hdrNet = '0;
  logic [2:0]  hdrLink = '0;
  logic [7:0]  linkIdle = '0;
  logic        resValid, resLocal, resStatic, resErr, resBusy;
  logic [3:0]  resDir;
  logic [2:0]  resLink;
  logic [7:0]  resChanEnd;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  mism_router u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .hdrValid(hdrValid),
    .hdrDest(hdrDest), .hdrNet(hdrNet), .hdrLink(hdrLink), .linkIdle(linkIdle),
    .resValid(resValid), .resLocal(resLocal), .resStatic(resStatic),
    .resErr(resErr), .resBusy(resBusy), .resDir(resDir), .resLink(resLink),
    .resChanEnd(resChanEnd)
  );

  typedef struct packed {
    logic [15:0] dest;
    logic [1:0]  net;
    logic [2:0]  inLink;
    logic [7:0]  idle;
    logic [3:0]  flags;   // {local, static, err, busy}
    logic [3:0]  dir;
    logic [2:0]  lnk;
    logic [7:0]  chan;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{16'h5A3C, 2'd0, 3'd0, 8'hFF, 4'b1000, 4'h0, 3'd0, 8'h00}, // R4 local
    '{16'hDA3C, 2'd0, 3'd0, 8'hFF, 4'b0000, 4'hF, 3'd0, 8'h00}, // R6 bit15
    '{16'hDA3C, 2'd0, 3'd0, 8'hFE, 4'b0000, 4'hF, 3'd1, 8'h00}, // R6 next idle
    '{16'hDA3C, 2'd0, 3'd0, 8'hFC, 4'b0001, 4'hF, 3'd0, 8'h00}, // R8 busy
    '{16'h5A34, 2'd1, 3'd0, 8'hFF, 4'b0000, 4'h3, 3'd2, 8'h00}, // R5 bit3
    '{16'h5A34, 2'd1, 3'd0, 8'hFB, 4'b0000, 4'h3, 3'd4, 8'h00}, // R10 skip static L3
    '{16'h5A34, 2'd0, 3'd0, 8'hFF, 4'b0010, 4'h3, 3'd0, 8'h00}, // R7 net miss
    '{16'h5C3C, 2'd0, 3'd0, 8'hFF, 4'b0010, 4'hA, 3'd0, 8'h00}, // R7 bit10
    '{16'h583C, 2'd2, 3'd0, 8'hFF, 4'b0000, 4'h9, 3'd5, 8'h00}, // R5 bit9
    '{16'h5A3D, 2'd0, 3'd0, 8'hFF, 4'b0000, 4'h0, 3'd6, 8'h00}, // R5 bit0
    '{16'h4A3C, 2'd3, 3'd0, 8'hFF, 4'b0000, 4'hC, 3'd7, 8'h00}, // R5 bit12
    '{16'h1234, 2'd0, 3'd3, 8'hFF, 4'b0100, 4'h0, 3'd0, 8'h42}, // R9 static
    '{16'h5A3C, 2'd0, 3'd3, 8'hFF, 4'b0100, 4'h0, 3'd0, 8'h42}, // R9 over local
    '{16'h5A3D, 2'd1, 3'd0, 8'hFF, 4'b0010, 4'h0, 3'd0, 8'h00}, // R7 bit0 net1
    '{16'hFFFF, 2'd0, 3'd0, 8'h00, 4'b0001, 4'hF, 3'd0, 8'h00}  // R8 none idle
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgAddr = a; cfgWrData = d; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgRead(input logic [5:0] a, output logic [31:0] d);
    cfgAddr = a;
    #1;
    d = cfgRdData;
  endtask

  // present a header for one cycle; on return outputs carry its result
  task automatic sendHdr(input logic [15:0] d, input logic [1:0] n,
                         input logic [2:0] l, input logic [7:0] idle);
    @(negedge clk);
    hdrDest = d; hdrNet = n; hdrLink = l; linkIdle = idle; hdrValid = 1'b1;
    @(negedge clk);
    hdrValid = 1'b0;
  endtask

  function automatic logic [31:0] lnkWord(input logic st, input logic [1:0] n,
                                          input logic [3:0] dr, input logic [7:0] ch);
    return {st, 5'd0, n, 4'd0, dr, 8'd0, ch};
  endfunction

  function automatic string tagOf(input logic [3:0] f);
    if (f[3]) return "R4";
    if (f[2]) return "R9";
    if (f[1]) return "R7";
    if (f[0]) return "R8";
    return "R6";
  endfunction

  logic [31:0] rd;
  logic [22:0] snapA;

  initial begin
    #(20 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 resValid", 64'(resValid), 64'd0);
    cfgRead(6'd1, rd);  check("R1 local", 64'(rd), 64'd0);
    cfgRead(6'd3, rd);  check("R1 dirHi", 64'(rd), 64'd0);
    cfgRead(6'd12, rd); check("R1 link4", 64'(rd), 64'd0);
    rstN = 1'b1;

    // configuration
    cfgWrite(6'd1, 32'hFFFF_5A3C);
    cfgWrite(6'd2, 32'h7654_3210);
    cfgWrite(6'd3, 32'hFEDC_BA98);
    cfgWrite(6'd8,  lnkWord(1'b0, 2'd0, 4'hF, 8'h00));
    cfgWrite(6'd9,  lnkWord(1'b0, 2'd0, 4'hF, 8'h00));
    cfgWrite(6'd10, lnkWord(1'b0, 2'd1, 4'h3, 8'h00));
    cfgWrite(6'd11, lnkWord(1'b1, 2'd1, 4'h3, 8'h42));
    cfgWrite(6'd12, lnkWord(1'b0, 2'd1, 4'h3, 8'h00));
    cfgWrite(6'd13, lnkWord(1'b0, 2'd2, 4'h9, 8'h00));
    cfgWrite(6'd14, lnkWord(1'b0, 2'd0, 4'h0, 8'h00));
    cfgWrite(6'd15, 32'h7FFF_FFFF & lnkWord(1'b0, 2'd3, 4'hC, 8'h00) | 32'h00F0_FF00);

    // R2 readback, masking and unmapped address
    cfgRead(6'd1, rd);  check("R2 local mask", 64'(rd), 64'h0000_5A3C);
    cfgRead(6'd3, rd);  check("R2 dirHi", 64'(rd), 64'hFEDC_BA98);
    cfgRead(6'd11, rd); check("R2 static link", 64'(rd), 64'h8103_0042);
    cfgRead(6'd15, rd); check("R2 link7 mask", 64'(rd), 64'h030C_0000);
    cfgWrite(6'd4, 32'hDEAD_BEEF);
    cfgRead(6'd4, rd);  check("R2 unmapped", 64'(rd), 64'd0);
    cfgRead(6'd1, rd);  check("R2 local untouched", 64'(rd), 64'h0000_5A3C);

    // vector table
    for (int v = 0; v < NV; v++) begin
      sendHdr(VT[v].dest, VT[v].net, VT[v].inLink, VT[v].idle);
      check($sformatf("%s vec%0d valid", tagOf(VT[v].flags), v), 64'(resValid), 64'd1);
      check($sformatf("%s vec%0d", tagOf(VT[v].flags), v),
            64'({resLocal, resStatic, resErr, resBusy, resDir, resLink, resChanEnd}),
            64'({VT[v].flags, VT[v].dir, VT[v].lnk, VT[v].chan}));
    end

    // R3 single-cycle valid and hold
    sendHdr(16'h583C, 2'd2, 3'd0, 8'hFF);
    snapA = {resLocal, resStatic, resErr, resBusy, resDir, resLink, resChanEnd};
    linkIdle = 8'h00; hdrDest = 16'h5A3C;
    @(negedge clk);
    check("R3 valid drops", 64'(resValid), 64'd0);
    check("R3 hold", 64'({resLocal, resStatic, resErr, resBusy, resDir, resLink, resChanEnd}),
          64'(snapA));

    // R10 only static and one routed candidate idle
    sendHdr(16'h5A34, 2'd1, 3'd0, 8'h18);
    check("R10 static excluded", 64'({resErr, resBusy, resLink}), 64'({1'b0, 1'b0, 3'd4}));

    // R5 reprogrammed entry for position 15
    cfgWrite(6'd3, 32'h5EDC_BA98);
    sendHdr(16'hDA3C, 2'd0, 3'd0, 8'hFF);
    check("R5 reprog dir", 64'({resErr, resDir}), 64'({1'b1, 4'h5}));

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule